// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Sequencer

This block runs the external bus of a small 8-bit processor whose low address byte and data byte share one set of pins. A core-side request names one of five machine-cycle kinds, a 16-bit address and a write byte. The sequencer then steps through the T-states of that cycle. It drives the high address byte on dedicated lines and puts the low address byte on the shared bus with an address-latch strobe. After that it raises active-low read or write strobes with the right timing, and holds a three-bit status code for the whole cycle. When the cycle ends it returns the read byte with a one-clock done pulse.

The block runs at twice the T-state rate. Every T-state is therefore two clocks, a first half and a second half, and the mid-state strobe edges fall on clock edges. A fetch cycle also loads the fetched byte into an instruction byte register, and its fourth T-state leaves the bus quiet for decode.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, so a request held during a cycle waits without back-pressure logic in the core. The response side has no ready: `rsp_valid` is a single-clock pulse and the core must take `rsp_rdata` in that clock. `rsp_rdata` then holds until the next read.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset, and in every idle clock, `tstate` is 0, `req_ready` is 1, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and {io_m,s1,s0} is 000. No request is taken while a cycle runs, and the address of the running cycle stays on `addr_hi`.
- R2: From the first clock of a cycle to its last, `addr_hi` shows address bits 15:8. During T1 `ad_oe` is 1 and `ad_out` shows address bits 7:0.
- R3: `ale` is 1 in the first half of T1 only, for exactly one clock per cycle.
- R4: In read-type cycles `rd_n` is 0 from the start of T2 through the first half of T3, and `ad_oe` is 0 from T2 on. The byte on `ad_in` during the first half of T3 is the byte returned.
- R5: In write cycles `wr_n` is 0 from the start of T2 through the first half of T3. `ad_oe` stays 1 and `ad_out` shows the write byte from T2 to the end of T3. `rd_n` and `wr_n` are never both 0.
- R6: {io_m,s1,s0} is held for the whole cycle: fetch 011, memory read 010, memory write 001, I/O read 110, I/O write 101.
- R7: `tstate` counts 1,2,3(,4), two clocks each. A fetch takes 4 T-states and every other kind takes 3, so a fetch, two memory reads and a memory write take 26 bus clocks in total.
- R8: `rsp_valid` is 1 for one clock, the second half of the last T-state. In a read-type cycle `rsp_rdata` then holds the byte sampled in T3.
- R9: A fetch loads the sampled byte into `instr_byte`, and its T4 has both strobes high and `ad_oe` 0. Other kinds leave `instr_byte` unchanged.
- R10: `req_kind` codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write. Codes 5 to 7 are consumed by the handshake but start no cycle and give no done pulse.
- R11: A request held high across the done pulse is taken in the idle clock that follows it, and its T1 starts in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the T-state rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 3 | Machine-cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Byte read by the last read-type cycle |
| instr_byte | output | 8 | Last fetched byte |
| tstate | output | 3 | Current T-state number, 0 when idle |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared bus output byte |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |

## Verification
The coincidence that matters is the done pulse of one cycle and a new request from the core landing in the same clock. The bench raises a request during T1 of a running write and holds it. It then checks four things: `req_ready` stays low to the end, `addr_hi` keeps the first address, the done pulse comes on schedule, and the waiting request is taken only in the idle clock after it, with its T1 one clock later. A second case puts a decoy byte on `ad_in` in every half-state except the first half of T3. This shows that the capture and the rising read strobe in that same T-state use the right half.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    BK_FETCH  = 3'd0,
    BK_MEM_RD = 3'd1,
    BK_MEM_WR = 3'd2,
    BK_IO_RD  = 3'd3,
    BK_IO_WR  = 3'd4
  } bus_kind_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } bus_status_t;

  localparam bus_status_t STATUS_IDLE = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};

  function automatic logic kind_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic kind_reads(input bus_kind_e k);
    return (k == BK_FETCH) || (k == BK_MEM_RD) || (k == BK_IO_RD);
  endfunction

  function automatic logic kind_writes(input bus_kind_e k);
    return (k == BK_MEM_WR) || (k == BK_IO_WR);
  endfunction

  function automatic bus_status_t kind_status(input bus_kind_e k);
    bus_status_t st;
    case (k)
      BK_FETCH:  st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      BK_MEM_RD: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      BK_MEM_WR: st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      BK_IO_RD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      BK_IO_WR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default:   st = STATUS_IDLE;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/mbus_tstate_ctr.sv
module mbus_tstate_ctr #(
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3,
  parameter int TS_W    = $clog2(FETCH_T + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_fetch,
  output logic            busy,
  output logic [TS_W-1:0] tst,
  output logic            half,
  output logic            done
);

  logic [TS_W-1:0] last_t;
  logic            at_last;

  assign last_t  = is_fetch ? TS_W'(FETCH_T) : TS_W'(XFER_T);
  assign at_last = (tst == last_t);
  assign done    = busy && half && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tst  <= '0;
      half <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      tst  <= TS_W'(1);
      half <= 1'b0;
    end else if (busy) begin
      if (!half) begin
        half <= 1'b1;
      end else if (at_last) begin
        busy <= 1'b0;
        tst  <= '0;
        half <= 1'b0;
      end else begin
        tst  <= tst + TS_W'(1);
        half <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
  import mbus_pkg::*;
#(
  parameter int TS_W = 3
) (
  input  logic            busy,
  input  logic [TS_W-1:0] tst,
  input  logic            half,
  input  bus_kind_e       kind,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            ad_oe,
  output logic            ad_data_sel,
  output logic            rd_sample,
  output bus_status_t     status
);

  logic in_t1, in_t2, in_t3, strobe_win, rd_kind, wr_kind;

  assign in_t1   = busy && (tst == TS_W'(1));
  assign in_t2   = busy && (tst == TS_W'(2));
  assign in_t3   = busy && (tst == TS_W'(3));
  assign rd_kind = kind_reads(kind);
  assign wr_kind = kind_writes(kind);

  // strobes span T2 and the first half of T3
  assign strobe_win = in_t2 || (in_t3 && !half);

  always_comb begin
    ale         = in_t1 && !half;
    rd_n        = !(rd_kind && strobe_win);
    wr_n        = !(wr_kind && strobe_win);
    ad_oe       = in_t1 || (wr_kind && (in_t2 || in_t3));
    ad_data_sel = !in_t1;
    rd_sample   = rd_kind && in_t3 && !half;
    status      = busy ? kind_status(kind) : STATUS_IDLE;
  end

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int HI_W   = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_sample,
  input  logic              ad_data_sel,
  input  logic [DATA_W-1:0] ad_in,
  output bus_kind_e         kind_q,
  output logic              is_fetch,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ir
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q  <= BK_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ir      <= '0;
    end else begin
      if (start) begin
        kind_q  <= bus_kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) begin
        rdata <= ad_in;
        if (kind_q == BK_FETCH) ir <= ad_in;
      end
    end
  end

  assign is_fetch = (kind_q == BK_FETCH);
  assign addr_hi  = addr_q[ADDR_W-1:DATA_W];
  assign ad_out   = ad_data_sel ? wdata_q : addr_q[DATA_W-1:0];

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int XFER_T  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [2:0]                      req_kind,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic [DATA_W-1:0]               instr_byte,
  output logic [$clog2(FETCH_T+1)-1:0]    tstate,
  output logic [ADDR_W-DATA_W-1:0]        addr_hi,
  output logic [DATA_W-1:0]               ad_out,
  output logic                            ad_oe,
  input  logic [DATA_W-1:0]               ad_in,
  output logic                            ale,
  output logic                            rd_n,
  output logic                            wr_n,
  output logic                            io_m,
  output logic                            s1,
  output logic                            s0
);

  localparam int TS_W = $clog2(FETCH_T + 1);
  localparam int HI_W = ADDR_W - DATA_W;

  logic            busy, half, start, is_fetch, ad_data_sel, rd_sample;
  logic [TS_W-1:0] tst;
  bus_kind_e       kind_q;
  bus_status_t     status;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready && kind_ok(req_kind);

  mbus_tstate_ctr #(
    .FETCH_T (FETCH_T),
    .XFER_T  (XFER_T),
    .TS_W    (TS_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .is_fetch (is_fetch),
    .busy     (busy),
    .tst      (tst),
    .half     (half),
    .done     (rsp_valid)
  );

  mbus_strobe_gen #(
    .TS_W (TS_W)
  ) u_strobe (
    .busy        (busy),
    .tst         (tst),
    .half        (half),
    .kind        (kind_q),
    .ale         (ale),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ad_oe       (ad_oe),
    .ad_data_sel (ad_data_sel),
    .rd_sample   (rd_sample),
    .status      (status)
  );

  mbus_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .HI_W   (HI_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_kind    (req_kind),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_sample   (rd_sample),
    .ad_data_sel (ad_data_sel),
    .ad_in       (ad_in),
    .kind_q      (kind_q),
    .is_fetch    (is_fetch),
    .addr_hi     (addr_hi),
    .ad_out      (ad_out),
    .rdata       (rsp_rdata),
    .ir          (instr_byte)
  );

  assign tstate = tst;
  assign io_m   = status.io_m;
  assign s1     = status.s1;
  assign s0     = status.s0;

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk #(
  parameter int TS_W = 3,
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            ad_oe,
  input logic [TS_W-1:0] tstate,
  input logic [HI_W-1:0] addr_hi,
  input logic            io_m,
  input logic            s1,
  input logic            s0
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ale && !ad_oe && {io_m, s1, s0} == 3'b000 && tstate == '0));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != '0 && !ale) |-> $stable(addr_hi));

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_in_t1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (tstate == TS_W'(1)));

  p_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_write_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tstate != '0 && !ale) |-> $stable({io_m, s1, s0}));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_done_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (req_ready && tstate == '0));

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk #(
  .TS_W ($clog2(FETCH_T + 1)),
  .HI_W (ADDR_W - DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ale       (ale),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .tstate    (tstate),
  .addr_hi   (addr_hi),
  .io_m      (io_m),
  .s1        (s1),
  .s0        (s0)
);

// File: tb/mbus_cycle_seq_tb_top.sv
module mbus_cycle_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [7:0]  instr_byte;
  logic [2:0]  tstate;
  logic [7:0]  addr_hi;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic        ale, rd_n, wr_n, io_m, s1, s0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit cnt_en = 1'b0;
  int act_cnt = 0;

  always #4 clk = ~clk;

  mbus_cycle_seq dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_kind (req_kind),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .instr_byte (instr_byte),
    .tstate (tstate), .addr_hi (addr_hi), .ad_out (ad_out), .ad_oe (ad_oe),
    .ad_in (ad_in), .ale (ale), .rd_n (rd_n), .wr_n (wr_n),
    .io_m (io_m), .s1 (s1), .s0 (s0)
  );

  always @(negedge clk) if (cnt_en && tstate != 3'd0) act_cnt++;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_status(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction

  task automatic chk_idle(input string req);
    chk(req, "tstate", 32'(tstate), 32'd0);
    chk(req, "req_ready", 32'(req_ready), 32'd1);
    chk(req, "ale", 32'(ale), 32'd0);
    chk(req, "rd_n", 32'(rd_n), 32'd1);
    chk(req, "wr_n", 32'(wr_n), 32'd1);
    chk(req, "ad_oe", 32'(ad_oe), 32'd0);
    chk(req, "status", 32'({io_m, s1, s0}), 32'd0);
  endtask

  // one full machine cycle; ad_in carries the real byte only in the first half of T3
  task automatic run_cycle(input logic [2:0] kind, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rv,
                           output logic [7:0] got);
    bit rdk, wrk;
    int nhalf;
    rdk   = (kind == 3'd0) || (kind == 3'd1) || (kind == 3'd3);
    wrk   = (kind == 3'd2) || (kind == 3'd4);
    nhalf = (kind == 3'd0) ? 8 : 6;
    got   = 8'h00;
    @(negedge clk);
    req_kind = kind; req_addr = addr; req_wdata = wd; req_valid = 1'b1; ad_in = ~rv;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < nhalf; i++) begin
      if (i > 0) @(negedge clk);
      ad_in = (i == 4) ? rv : ~rv;
      chk("R7", "tstate", 32'(tstate), 32'(i / 2 + 1));
      chk("R3", "ale", 32'(ale), 32'(i == 0));
      chk("R4", "rd_n", 32'(rd_n), 32'(!(rdk && i >= 2 && i <= 4)));
      chk("R5", "wr_n", 32'(wr_n), 32'(!(wrk && i >= 2 && i <= 4)));
      chk(wrk ? "R5" : "R4", "ad_oe", 32'(ad_oe), 32'((i < 2) || (wrk && i < 6)));
      if (i < 2) chk("R2", "ad_out addr", 32'(ad_out), 32'(addr[7:0]));
      else if (wrk && i < 6) chk("R5", "ad_out data", 32'(ad_out), 32'(wd));
      chk("R2", "addr_hi", 32'(addr_hi), 32'(addr[15:8]));
      chk("R6", "status", 32'({io_m, s1, s0}), 32'(exp_status(kind)));
      chk("R8", "rsp_valid", 32'(rsp_valid), 32'(i == nhalf - 1));
      chk("R1", "req_ready busy", 32'(req_ready), 32'd0);
      if (i == nhalf - 1) begin
        got = rsp_rdata;
        if (rdk) chk("R4", "rsp_rdata", 32'(rsp_rdata), 32'(rv));
      end
    end
    @(negedge clk);
    chk_idle("R7");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_addr = '0; req_wdata = '0; ad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fetch;
    logic [7:0] g;
    run_cycle(3'd0, 16'h1234, 8'h00, 8'h3A, g);
    chk("R9", "instr_byte", 32'(instr_byte), 32'h3A);
  endtask

  task automatic t_mem_read;
    logic [7:0] g;
    run_cycle(3'd1, 16'hA55A, 8'h00, 8'hC3, g);
    chk("R9", "instr_byte kept", 32'(instr_byte), 32'h3A);
  endtask

  task automatic t_mem_write;
    logic [7:0] g;
    run_cycle(3'd2, 16'h0FF0, 8'h96, 8'h00, g);
  endtask

  task automatic t_io_read;
    logic [7:0] g;
    run_cycle(3'd3, 16'h4444, 8'h00, 8'h7E, g);
    chk("R9", "instr_byte kept io", 32'(instr_byte), 32'h3A);
  endtask

  task automatic t_io_write;
    logic [7:0] g;
    run_cycle(3'd4, 16'h8181, 8'h5C, 8'h00, g);
  endtask

  task automatic t_bad_kind;
    @(negedge clk);
    req_kind = 3'd6; req_addr = 16'hBEEF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk_idle("R10");
      chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_kind = 3'd2; req_addr = 16'h2211; req_wdata = 8'h44; req_valid = 1'b1;
    @(negedge clk);
    // first cycle in T1: swap fields to a second request and keep it asserted
    req_kind = 3'd1; req_addr = 16'h6655; ad_in = 8'h99;
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      chk("R1", "req_ready held", 32'(req_ready), 32'd0);
      chk("R1", "addr_hi first", 32'(addr_hi), 32'h22);
      chk("R8", "rsp_valid", 32'(rsp_valid), 32'(i == 5));
    end
    @(negedge clk);
    chk("R11", "idle tstate", 32'(tstate), 32'd0);
    chk("R11", "idle ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "next tstate", 32'(tstate), 32'd1);
    chk("R11", "next ale", 32'(ale), 32'd1);
    chk("R11", "next addr_hi", 32'(addr_hi), 32'h66);
    for (int i = 0; i < 20 && tstate != 3'd0; i++) @(negedge clk);
    chk_idle("R11");
  endtask

  task automatic t_store_direct;
    logic [7:0] lo, hi, op;
    act_cnt = 0;
    cnt_en = 1'b1;
    run_cycle(3'd0, 16'h0100, 8'h00, 8'h32, op);
    run_cycle(3'd1, 16'h0101, 8'h00, 8'h6A, lo);
    run_cycle(3'd1, 16'h0102, 8'h00, 8'h52, hi);
    run_cycle(3'd2, {hi, lo}, 8'hE1, 8'h00, op);
    cnt_en = 1'b0;
    chk("R7", "store-direct bus clocks", 32'(act_cnt), 32'd26);
    chk("R9", "store-direct opcode", 32'(instr_byte), 32'h32);
  endtask

  initial begin
    t_reset();
    t_fetch();
    t_mem_read();
    t_mem_write();
    t_io_read();
    t_io_write();
    t_bad_kind();
    t_back_to_back();
    t_store_direct();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule